// File: doc/BRIEF.md
# UART Register Bank with Interrupt Logic

This block is the processor-facing register front end of a UART. It exposes a 4 KB window of word-aligned registers on a simple single-cycle bus. A transaction is one cycle of `bus_valid`, carrying a write flag, a byte address and write data. Read data is registered and appears the cycle after the request. The serial shifter, the baud generator and the receive buffer are separate blocks. This bank sends each written character to the transmitter with a one-cycle strobe. It pops characters from an external receive buffer, whose head entry, fill count and empty/full state come back in through input ports.

The bank stores the divisor, IrDA, line control, control, FIFO-level and DMA control values and reads them back. It has no further use for any of them, except the FIFO-enable bit of line control: toggling that bit flushes the receive buffer. It keeps raw transmit and receive interrupt bits and a mask. Its single interrupt output is high whenever a raw bit and its mask bit are both set. A read of the data register returns the buffer head and captures that entry's error bits into a receive status register. Eight fixed identification bytes occupy the top of the window.

Top module: `uart_regbank`

## Requirements
- R1: After reset, control (index 12) reads 0x300, FIFO level (index 13) reads 0x12, the mask and all other stored registers read 0, both raw interrupt bits are 0 and `irq` is 0.
- R2: The register index is address bits [11:2]. A read returns the value selected by that index on `bus_rdata` one cycle later. Stored widths are: IrDA (8) 8 bits, integer divisor (9) 16, fractional divisor (10) 6, line control (11) 8, control (12) 16, FIFO level (13) 6, mask (14) 11 and DMA control (18) 3. Upper write bits are dropped.
- R3: Byte addresses 0xFE0 to 0xFFC read, in address order, 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05 and 0xB1.
- R4: Undecoded indices and the write-only clear register (index 17) read as 0. Writes to undecoded indices change nothing.
- R5: A write to index 0 pulses `tx_valid` in the same cycle, with `tx_data` equal to write bits [7:0]. It also sets raw transmit interrupt bit 5.
- R6: Raw status (index 15) holds the transmit bit at 5 and the receive bit at 4. Masked status (index 16) is raw AND mask. `irq` is high when masked status is nonzero, from the clock edge that ends a mask write. A write to index 17 clears each raw bit written as 1.
- R7: Raw receive bit 4 is set when `rx_count` equals the trigger level (parameter, default 1) and the count seen in the previous cycle was below it. In the same cycle, a set takes priority over any clear.
- R8: A read of index 0 returns the 12-bit `rx_head` and pulses `rx_pop` when `rx_empty` is low. It clears raw receive bit 4 when the count left after the pop (0 when empty) equals the trigger level minus one.
- R9: A read of index 0 loads receive status (index 1) with `rx_head[11:8]`. Any write to index 1 zeroes it.
- R10: Flag register (index 6) reads bit 7 = 1 (transmitter empty), bit 6 = `rx_full`, bit 5 = 0 and bit 4 = `rx_empty`. Writes to it change no stored state.
- R11: A line-control write that flips bit 4 relative to the stored value pulses `rx_flush` in that cycle. A write that keeps bit 4 does not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Transaction this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_valid | output | 1 | Character strobe to transmitter |
| tx_data | output | 8 | Character to transmit |
| rx_pop | output | 1 | Pop request to receive buffer |
| rx_head | input | 12 | Receive buffer head: error bits [11:8], character [7:0] |
| rx_count | input | 5 | Receive buffer fill count |
| rx_empty | input | 1 | Receive buffer empty |
| rx_full | input | 1 | Receive buffer full |
| rx_flush | output | 1 | Flush request to receive buffer |
| irq | output | 1 | Combined interrupt |

## Verification
Two events can meet in one cycle: a write to the clear register, and the receive count crossing up to the trigger level. The bench provokes this by raising `rx_count` from 0 to 1 on the very cycle that the clear register is written with bit 4 set. The read of raw status that follows must still show bit 4, and `irq` must stay high under the mask. A second contest pairs the pop-side clear with a count above the trigger level: the read leaves the interrupt set, and only the read that empties the count to below the trigger removes it.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int IDX_W   = ADDR_W - 2;
    localparam int HEAD_W  = 12;
    localparam int ERR_W   = 4;
    localparam int IRQ_W   = 11;

    localparam int TX_BIT  = 5;
    localparam int RX_BIT  = 4;
    localparam int FEN_BIT = 4;

    localparam int W_IRDA  = 8;
    localparam int W_BDI   = 16;
    localparam int W_BDF   = 6;
    localparam int W_LINE  = 8;
    localparam int W_CTRL  = 16;
    localparam int W_FLVL  = 6;
    localparam int W_DMA   = 3;

    localparam logic [W_CTRL-1:0] CTRL_RST = 16'h0300;
    localparam logic [W_FLVL-1:0] FLVL_RST = 6'h12;

    typedef enum logic [4:0] {
        RG_DATA = 5'd0,
        RG_STAT = 5'd1,
        RG_FLAG = 5'd6,
        RG_IRDA = 5'd8,
        RG_BDI  = 5'd9,
        RG_BDF  = 5'd10,
        RG_LINE = 5'd11,
        RG_CTRL = 5'd12,
        RG_FLVL = 5'd13,
        RG_MASK = 5'd14,
        RG_RAW  = 5'd15,
        RG_MSKD = 5'd16,
        RG_CLR  = 5'd17,
        RG_DMA  = 5'd18,
        RG_NONE = 5'd31
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e   sel;
        logic       id_hit;
        logic [2:0] id_idx;
    } dec_t;

    typedef struct packed {
        logic tx;
        logic rx;
    } irq_raw_t;

    function automatic logic [7:0] id_byte(input logic [2:0] i);
        case (i)
            3'd0: id_byte = 8'h11;
            3'd1: id_byte = 8'h10;
            3'd2: id_byte = 8'h14;
            3'd3: id_byte = 8'h00;
            3'd4: id_byte = 8'h0D;
            3'd5: id_byte = 8'hF0;
            3'd6: id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/uart_regbank_decode.sv
module uart_regbank_decode
    import uart_regbank_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    logic [IDX_W-1:0] idx;

    always_comb begin
        idx        = addr[ADDR_W-1:2];
        dec.id_hit = (addr[ADDR_W-1:5] == '1);
        dec.id_idx = addr[4:2];
        case (idx)
            10'd0:   dec.sel = RG_DATA;
            10'd1:   dec.sel = RG_STAT;
            10'd6:   dec.sel = RG_FLAG;
            10'd8:   dec.sel = RG_IRDA;
            10'd9:   dec.sel = RG_BDI;
            10'd10:  dec.sel = RG_BDF;
            10'd11:  dec.sel = RG_LINE;
            10'd12:  dec.sel = RG_CTRL;
            10'd13:  dec.sel = RG_FLVL;
            10'd14:  dec.sel = RG_MASK;
            10'd15:  dec.sel = RG_RAW;
            10'd16:  dec.sel = RG_MSKD;
            10'd17:  dec.sel = RG_CLR;
            10'd18:  dec.sel = RG_DMA;
            default: dec.sel = RG_NONE;
        endcase
    end

endmodule

// File: rtl/uart_regbank_irq.sv
module uart_regbank_irq
    import uart_regbank_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_set,
    input  logic             rx_set,
    input  logic             rx_clr,
    input  logic             clr_we,
    input  logic [IRQ_W-1:0] clr_bits,
    input  logic             mask_we,
    input  logic [IRQ_W-1:0] mask_wdata,
    output logic [IRQ_W-1:0] raw,
    output logic [IRQ_W-1:0] mask,
    output logic [IRQ_W-1:0] masked,
    output logic             irq
);
    irq_raw_t         raw_q;
    logic [IRQ_W-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            if (tx_set)
                raw_q.tx <= 1'b1;
            else if (clr_we && clr_bits[TX_BIT])
                raw_q.tx <= 1'b0;
            if (rx_set)
                raw_q.rx <= 1'b1;
            else if ((clr_we && clr_bits[RX_BIT]) || rx_clr)
                raw_q.rx <= 1'b0;
            if (mask_we)
                mask_q <= mask_wdata;
        end
    end

    always_comb begin
        raw         = '0;
        raw[TX_BIT] = raw_q.tx;
        raw[RX_BIT] = raw_q.rx;
        mask        = mask_q;
        masked      = raw & mask_q;
        irq         = |masked;
    end

    p_tx_set_r5: assert property (@(posedge clk) disable iff (rst)
        tx_set |=> raw_q.tx);

    p_icr_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_we && clr_bits[RX_BIT] && !rx_set) |=> !raw_q.rx);

    p_mask_irq_r6: assert property (@(posedge clk) disable iff (rst)
        (mask_we && (|(raw & mask_wdata))) |=> irq);

    p_rx_raise_r7: assert property (@(posedge clk) disable iff (rst)
        rx_set |=> raw_q.rx);

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_regbank_pkg::*;
#(
    parameter int RX_DEPTH = 16,
    parameter int RX_TRIG  = 1,
    localparam int CNT_W   = $clog2(RX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              rx_pop,
    input  logic [HEAD_W-1:0] rx_head,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic              rx_empty,
    input  logic              rx_full,
    output logic              rx_flush,
    output logic              irq
);
    localparam logic [CNT_W-1:0] TRIG_C = CNT_W'(RX_TRIG);

    dec_t               dec;
    logic               wr, rd, wr_data, rd_data;
    logic [W_IRDA-1:0]  irda_q;
    logic [W_BDI-1:0]   bdi_q;
    logic [W_BDF-1:0]   bdf_q;
    logic [W_LINE-1:0]  line_q;
    logic [W_CTRL-1:0]  ctrl_q;
    logic [W_FLVL-1:0]  flvl_q;
    logic [W_DMA-1:0]   dma_q;
    logic [ERR_W-1:0]   rsr_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   left_after;
    logic               rx_set, rx_clr;
    logic [IRQ_W-1:0]   raw, mask, masked;
    logic [DATA_W-1:0]  rd_mux, rdata_q;

    uart_regbank_decode u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    always_comb begin
        wr         = bus_valid && bus_write;
        rd         = bus_valid && !bus_write;
        wr_data    = wr && (dec.sel == RG_DATA);
        rd_data    = rd && (dec.sel == RG_DATA);
        left_after = (rx_count == '0) ? '0 : rx_count - 1'b1;
        rx_set     = (rx_count == TRIG_C) && (cnt_q < TRIG_C);
        rx_clr     = rd_data && (left_after == TRIG_C - 1'b1);
        rx_pop     = rd_data && !rx_empty;
        rx_flush   = wr && (dec.sel == RG_LINE)
                     && (line_q[FEN_BIT] != bus_wdata[FEN_BIT]);
        tx_valid   = wr_data;
        tx_data    = bus_wdata[7:0];
    end

    uart_regbank_irq u_irq (
        .clk        (clk),
        .rst        (rst),
        .tx_set     (wr_data),
        .rx_set     (rx_set),
        .rx_clr     (rx_clr),
        .clr_we     (wr && (dec.sel == RG_CLR)),
        .clr_bits   (bus_wdata[IRQ_W-1:0]),
        .mask_we    (wr && (dec.sel == RG_MASK)),
        .mask_wdata (bus_wdata[IRQ_W-1:0]),
        .raw        (raw),
        .mask       (mask),
        .masked     (masked),
        .irq        (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irda_q <= '0;
            bdi_q  <= '0;
            bdf_q  <= '0;
            line_q <= '0;
            ctrl_q <= CTRL_RST;
            flvl_q <= FLVL_RST;
            dma_q  <= '0;
            rsr_q  <= '0;
            cnt_q  <= '0;
        end else begin
            cnt_q <= rx_count;
            if (rd_data)
                rsr_q <= rx_head[HEAD_W-1:HEAD_W-ERR_W];
            if (wr) begin
                case (dec.sel)
                    RG_STAT: rsr_q  <= '0;
                    RG_IRDA: irda_q <= bus_wdata[W_IRDA-1:0];
                    RG_BDI:  bdi_q  <= bus_wdata[W_BDI-1:0];
                    RG_BDF:  bdf_q  <= bus_wdata[W_BDF-1:0];
                    RG_LINE: line_q <= bus_wdata[W_LINE-1:0];
                    RG_CTRL: ctrl_q <= bus_wdata[W_CTRL-1:0];
                    RG_FLVL: flvl_q <= bus_wdata[W_FLVL-1:0];
                    RG_DMA:  dma_q  <= bus_wdata[W_DMA-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        if (dec.id_hit) begin
            rd_mux = DATA_W'(id_byte(dec.id_idx));
        end else begin
            case (dec.sel)
                RG_DATA: rd_mux = DATA_W'(rx_head);
                RG_STAT: rd_mux = DATA_W'(rsr_q);
                RG_FLAG: rd_mux = DATA_W'({1'b1, rx_full, 1'b0, rx_empty, 4'b0000});
                RG_IRDA: rd_mux = DATA_W'(irda_q);
                RG_BDI:  rd_mux = DATA_W'(bdi_q);
                RG_BDF:  rd_mux = DATA_W'(bdf_q);
                RG_LINE: rd_mux = DATA_W'(line_q);
                RG_CTRL: rd_mux = DATA_W'(ctrl_q);
                RG_FLVL: rd_mux = DATA_W'(flvl_q);
                RG_MASK: rd_mux = DATA_W'(mask);
                RG_RAW:  rd_mux = DATA_W'(raw);
                RG_MSKD: rd_mux = DATA_W'(masked);
                RG_DMA:  rd_mux = DATA_W'(dma_q);
                default: rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (rd)
            rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;

    p_rsr_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (wr && dec.sel == RG_STAT) |=> (rsr_q == '0));

    p_flag_ignore_r10: assert property (@(posedge clk) disable iff (rst)
        (wr && dec.sel == RG_FLAG)
        |=> $stable({irda_q, bdi_q, bdf_q, line_q, ctrl_q, flvl_q, dma_q, rsr_q}));

endmodule

// File: tb/uart_regbank_bench.sv
module uart_regbank_bench;
    import uart_regbank_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              tx_valid, rx_pop, rx_flush, irq;
    logic [7:0]        tx_data;
    logic [HEAD_W-1:0] rx_head = '0;
    logic [4:0]        rx_count = '0;
    logic              rx_empty = 1'b1;
    logic              rx_full = 1'b0;

    int checks = 0;
    int errors = 0;
    logic c_tx, c_pop, c_flush;
    logic [7:0] c_txd;

    always #2 clk = ~clk;

    uart_regbank u_uart_regbank (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .rx_pop(rx_pop),
        .rx_head(rx_head), .rx_count(rx_count), .rx_empty(rx_empty),
        .rx_full(rx_full), .rx_flush(rx_flush), .irq(irq)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 12'h030, 32'h0, 32'h300},          // R1 control reset
        '{1'b0, 12'h034, 32'h0, 32'h12},           // R1 FIFO level reset
        '{1'b0, 12'h018, 32'h0, 32'h90},           // R10 flags at reset
        '{1'b0, 12'h038, 32'h0, 32'h0},            // R1 mask reset
        '{1'b0, 12'h03C, 32'h0, 32'h0},            // R1 raw reset
        '{1'b1, 12'h024, 32'h12345678, 32'h0},     // R2
        '{1'b0, 12'h024, 32'h0, 32'h5678},
        '{1'b1, 12'h028, 32'hFF, 32'h0},
        '{1'b0, 12'h028, 32'h0, 32'h3F},
        '{1'b1, 12'h020, 32'h1AB, 32'h0},
        '{1'b0, 12'h020, 32'h0, 32'hAB},
        '{1'b1, 12'h030, 32'hFFFFF, 32'h0},
        '{1'b0, 12'h031, 32'h0, 32'hFFFF},         // R2 low address bits ignored
        '{1'b1, 12'h034, 32'hFF, 32'h0},
        '{1'b0, 12'h034, 32'h0, 32'h3F},
        '{1'b1, 12'h048, 32'hF, 32'h0},
        '{1'b0, 12'h048, 32'h0, 32'h7},
        '{1'b1, 12'h018, 32'h0, 32'h0},            // R10 flag write
        '{1'b0, 12'h018, 32'h0, 32'h90},
        '{1'b0, 12'h044, 32'h0, 32'h0},            // R4 clear reg reads 0
        '{1'b1, 12'h050, 32'hFF, 32'h0},           // R4 undecoded write
        '{1'b0, 12'h050, 32'h0, 32'h0},
        '{1'b0, 12'hFE0, 32'h0, 32'h11},           // R3 id bytes
        '{1'b0, 12'hFE4, 32'h0, 32'h10},
        '{1'b0, 12'hFE8, 32'h0, 32'h14},
        '{1'b0, 12'hFEC, 32'h0, 32'h00},
        '{1'b0, 12'hFF0, 32'h0, 32'h0D},
        '{1'b0, 12'hFF4, 32'h0, 32'hF0},
        '{1'b0, 12'hFF8, 32'h0, 32'h05},
        '{1'b0, 12'hFFC, 32'h0, 32'hB1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic op(input logic w, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_wdata = d;
        #1;
        c_tx = tx_valid; c_txd = tx_data; c_pop = rx_pop; c_flush = rx_flush;
        @(negedge clk);
        bus_valid = 1'b0;
        #1;
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 rdata", bus_rdata, 32'h0);

        for (int i = 0; i < NV; i++) begin
            op(TBL[i].wr, TBL[i].addr, TBL[i].data);
            if (!TBL[i].wr)
                chk($sformatf("R2/R3/R4/R10 vec %0d", i), bus_rdata, TBL[i].exp);
        end

        // R5 transmit strobe and raw bit
        op(1'b1, 12'h000, 32'h1C5);
        chk("R5 tx_valid", {31'b0, c_tx}, 32'h1);
        chk("R5 tx_data", {24'b0, c_txd}, 32'hC5);
        op(1'b0, 12'h03C, 0);
        chk("R5 raw tx", bus_rdata, 32'h20);
        chk("R6 irq masked off", {31'b0, irq}, 32'h0);
        op(1'b1, 12'h038, 32'h20);
        chk("R6 irq after mask", {31'b0, irq}, 32'h1);
        op(1'b0, 12'h040, 0);
        chk("R6 masked status", bus_rdata, 32'h20);
        op(1'b1, 12'h044, 32'h10);
        op(1'b0, 12'h03C, 0);
        chk("R6 clear other bit", bus_rdata, 32'h20);
        op(1'b1, 12'h044, 32'h20);
        op(1'b0, 12'h03C, 0);
        chk("R6 clear tx", bus_rdata, 32'h0);
        chk("R6 irq low", {31'b0, irq}, 32'h0);

        // R7 receive raise
        @(negedge clk);
        rx_count = 5'd1; rx_empty = 1'b0; rx_head = 12'h5A3;
        op(1'b0, 12'h03C, 0);
        chk("R7 raw rx", bus_rdata, 32'h10);
        op(1'b1, 12'h038, 32'h30);
        chk("R6 irq rx", {31'b0, irq}, 32'h1);
        op(1'b0, 12'h018, 0);
        chk("R10 flags nonempty", bus_rdata, 32'h80);

        // R8 pop and clear, R9 status capture
        op(1'b0, 12'h000, 0);
        chk("R8 pop", {31'b0, c_pop}, 32'h1);
        chk("R8 head", bus_rdata, 32'h5A3);
        rx_count = 5'd0; rx_empty = 1'b1;
        op(1'b0, 12'h03C, 0);
        chk("R8 rx cleared", bus_rdata, 32'h0);
        op(1'b0, 12'h004, 0);
        chk("R9 status", bus_rdata, 32'h5);
        op(1'b1, 12'h004, 32'hFF);
        op(1'b0, 12'h004, 0);
        chk("R9 status cleared", bus_rdata, 32'h0);
        op(1'b0, 12'h000, 0);
        chk("R8 no pop when empty", {31'b0, c_pop}, 32'h0);

        // R8 count above trigger keeps interrupt
        @(negedge clk);
        rx_count = 5'd1; rx_empty = 1'b0;
        @(negedge clk);
        rx_count = 5'd2;
        op(1'b0, 12'h000, 0);
        op(1'b0, 12'h03C, 0);
        chk("R8 count 2 keeps rx", bus_rdata, 32'h10);
        rx_count = 5'd1;
        op(1'b0, 12'h000, 0);
        op(1'b0, 12'h03C, 0);
        chk("R8 last pop clears", bus_rdata, 32'h0);
        rx_count = 5'd0; rx_empty = 1'b1;
        @(negedge clk);

        // R7 set beats clear in the same cycle
        @(negedge clk);
        rx_count = 5'd1; rx_empty = 1'b0;
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 12'h044; bus_wdata = 32'h30;
        @(negedge clk);
        bus_valid = 1'b0;
        op(1'b0, 12'h03C, 0);
        chk("R7 set wins over clear", bus_rdata, 32'h10);
        chk("R7 irq stays", {31'b0, irq}, 32'h1);

        // R10 full flag
        rx_full = 1'b1;
        op(1'b0, 12'h018, 0);
        chk("R10 full", bus_rdata, 32'hC0);
        rx_full = 1'b0;

        // R11 flush on FIFO-enable toggle
        op(1'b1, 12'h02C, 32'h10);
        chk("R11 flush on set", {31'b0, c_flush}, 32'h1);
        op(1'b1, 12'h02C, 32'h70);
        chk("R11 no flush", {31'b0, c_flush}, 32'h0);
        op(1'b0, 12'h02C, 0);
        chk("R2 line readback", bus_rdata, 32'h70);
        op(1'b1, 12'h02C, 32'h60);
        chk("R11 flush on clear", {31'b0, c_flush}, 32'h1);

        summary();
    end

endmodule